// File: doc/BRIEF.md
# Integer Execute Unit

This block is the single-cycle integer execute stage of a 64-bit load/store processor with fixed 32-bit instructions. Each cycle it can accept one instruction word with the two register operand values that the register file read for it. It then produces one of two things. For an integer operate instruction it produces a 64-bit result and a destination register index. For a memory-format instruction it produces a 64-bit effective byte address. All results appear on registered outputs one clock after the instruction is presented.

The operate path covers quadword and longword add and subtract, the three bitwise logic operations, and three compares. Its second operand is either the RB register or an 8-bit literal taken from the instruction. Arithmetic variants that carry the overflow-enable qualifier raise a trap flag on signed overflow and write nothing. Register index 31 is the hardwired zero register. Function codes and opcodes that are not recognised raise an illegal-instruction flag. The register file, the memory access and all exception handling sit outside the block.

Top module: `iexe_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, every output is cleared to zero at that edge.
- R2: The instruction fields are opcode [31:26], RA [25:21], RB [20:16] and RC [4:0]. Integer operate instructions use opcode 0x12. The outputs for an instruction sampled at one rising edge are valid after that same edge, and `out_valid` is set exactly when `in_valid` was sampled high.
- R3: Bit 12 of an operate instruction set to 1 selects literal mode. In literal mode the second operand is bits [20:13] zero-extended to 64 bits, and the RB operand value is not used.
- R4: A source index of 31 in RA or RB reads as zero, whatever value is on the matching operand input.
- R5: The function code is bits [11:5]. Code 0x01 writes RA + B and code 0x02 writes RA - B, both over the full 64 bits, with the result wrapping.
- R6: Code 0x03 (longword add) and code 0x04 (longword subtract) compute bits [31:0] of the sum or difference and copy bit 31 of that value into bits [63:32].
- R7: Code 0x10 writes RA AND B, code 0x11 writes RA OR B, and code 0x12 writes RA XOR B.
- R8: Code 0x20 (equal), code 0x21 (signed less than) and code 0x22 (unsigned less than) write 1 when the comparison is true and 0 when it is false.
- R9: Bit 6 of the function code is the overflow-enable qualifier, and it is legal only on codes 0x01 through 0x04. When it is set and the signed result overflows, `ovf_trap` is raised and `wr_en` stays low. The test is made on the 32-bit result for longword codes and on the 64-bit result for quadword codes. Without the qualifier, an overflow writes the wrapped result and no trap is raised.
- R10: Opcodes 0x28 through 0x2F are memory-format instructions. For these, `addr_valid` is set and `addr` is the RB value plus bits [15:0] sign-extended to 64 bits. No register write is made.
- R11: An operate result whose RC index is 31 is discarded: `wr_en` stays low.
- R12: Any other opcode, and any function code not listed in R5 to R9, sets `illegal`. In that case `wr_en`, `ovf_trap` and `addr_valid` all stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An instruction is presented this cycle |
| instr | input | 32 | Instruction word |
| ra_val | input | 64 | Value read for the RA register |
| rb_val | input | 64 | Value read for the RB register |
| out_valid | output | 1 | The outputs carry the result of an instruction |
| wr_en | output | 1 | Write `wr_data` into register `wr_idx` |
| wr_idx | output | 5 | Destination register index (RC) |
| wr_data | output | 64 | Operate result |
| addr_valid | output | 1 | `addr` holds a memory effective address |
| addr | output | 64 | Effective byte address |
| ovf_trap | output | 1 | An enabled integer overflow occurred |
| illegal | output | 1 | The opcode or function code is not recognised |

## Verification
The bench targets the overflow boundaries. A longword add of 0x7FFFFFFF and 1 must trap only with the qualifier set, while the same values under a quadword add must not trap. A design that judged overflow at the wrong width would trap on the wrong one of the two, or on neither. Literal operands are chosen so that their top bits look like RB index 31 and the literal's bit 7 is set. This exposes both zeroing a literal as if it were the zero register and sign-extending it. Negative displacements and a zero-register base test the address path, and the unsigned compare is run on operands that the signed compare orders the other way.

// File: rtl/iexe_pkg.sv
package iexe_pkg;

  localparam int OPW   = 6;
  localparam int FNW   = 7;
  localparam int IDXW  = 5;
  localparam int LITW  = 8;
  localparam int DISPW = 16;

  localparam logic [OPW-1:0]  OPC_INT     = 6'h12;
  localparam logic [2:0]      OPC_MEM_HI  = 3'b101;
  localparam logic [IDXW-1:0] ZERO_REG    = 5'd31;

  localparam logic [5:0] FN_ADDQ = 6'h01;
  localparam logic [5:0] FN_SUBQ = 6'h02;
  localparam logic [5:0] FN_ADDL = 6'h03;
  localparam logic [5:0] FN_SUBL = 6'h04;
  localparam logic [5:0] FN_AND  = 6'h10;
  localparam logic [5:0] FN_OR   = 6'h11;
  localparam logic [5:0] FN_XOR  = 6'h12;
  localparam logic [5:0] FN_CEQ  = 6'h20;
  localparam logic [5:0] FN_CLT  = 6'h21;
  localparam logic [5:0] FN_CULT = 6'h22;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR, ALU_CEQ, ALU_CLT, ALU_CULT
  } alu_op_e;

  typedef struct packed {
    logic    is_int;
    logic    is_mem;
    logic    bad;
    alu_op_e op;
    logic    is_long;
    logic    ovf_en;
    logic    use_lit;
  } dec_t;

endpackage

// File: rtl/iexe_decode.sv
module iexe_decode
  import iexe_pkg::*;
#(
  parameter int IW = 32
) (
  input  logic [IW-1:0]    instr,
  output dec_t             dec,
  output logic [IDXW-1:0]  ra_idx,
  output logic [IDXW-1:0]  rb_idx,
  output logic [IDXW-1:0]  rc_idx,
  output logic [LITW-1:0]  lit,
  output logic [DISPW-1:0] disp
);

  localparam int OP_LSB  = IW - OPW;
  localparam int RA_LSB  = OP_LSB - IDXW;
  localparam int RB_LSB  = RA_LSB - IDXW;
  localparam int LIT_LSB = RB_LSB + IDXW - LITW;
  localparam int SEL_BIT = LIT_LSB - 1;
  localparam int FN_LSB  = IDXW;

  logic [OPW-1:0] opc;
  logic [FNW-1:0] fn;
  logic           q_bit;
  logic [5:0]     fn_base;

  assign opc     = instr[IW-1:OP_LSB];
  assign ra_idx  = instr[RA_LSB +: IDXW];
  assign rb_idx  = instr[RB_LSB +: IDXW];
  assign rc_idx  = instr[IDXW-1:0];
  assign lit     = instr[LIT_LSB +: LITW];
  assign disp    = instr[DISPW-1:0];
  assign fn      = instr[FN_LSB +: FNW];
  assign q_bit   = fn[FNW-1];
  assign fn_base = fn[5:0];

  always_comb begin
    dec         = '0;
    dec.op      = ALU_ADD;
    dec.is_int  = (opc == OPC_INT);
    dec.is_mem  = (opc[OPW-1:OPW-3] == OPC_MEM_HI);
    dec.use_lit = instr[SEL_BIT];
    dec.ovf_en  = q_bit;
    if (dec.is_int) begin
      unique case (fn_base)
        FN_ADDQ: dec.op = ALU_ADD;
        FN_SUBQ: dec.op = ALU_SUB;
        FN_ADDL: begin dec.op = ALU_ADD; dec.is_long = 1'b1; end
        FN_SUBL: begin dec.op = ALU_SUB; dec.is_long = 1'b1; end
        FN_AND:  begin dec.op = ALU_AND;  dec.bad = q_bit; end
        FN_OR:   begin dec.op = ALU_OR;   dec.bad = q_bit; end
        FN_XOR:  begin dec.op = ALU_XOR;  dec.bad = q_bit; end
        FN_CEQ:  begin dec.op = ALU_CEQ;  dec.bad = q_bit; end
        FN_CLT:  begin dec.op = ALU_CLT;  dec.bad = q_bit; end
        FN_CULT: begin dec.op = ALU_CULT; dec.bad = q_bit; end
        default: dec.bad = 1'b1;
      endcase
    end else if (!dec.is_mem) begin
      dec.bad = 1'b1;
    end
  end

endmodule

// File: rtl/iexe_opsel.sv
module iexe_opsel
  import iexe_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [IDXW-1:0] ra_idx,
  input  logic [IDXW-1:0] rb_idx,
  input  logic [XLEN-1:0] ra_val,
  input  logic [XLEN-1:0] rb_val,
  input  logic [LITW-1:0] lit,
  input  logic            use_lit,
  output logic [XLEN-1:0] a_op,
  output logic [XLEN-1:0] rb_z,
  output logic [XLEN-1:0] b_op
);

  localparam int PADW = XLEN - LITW;

  logic [XLEN-1:0] lit_ext;

  assign lit_ext = {{PADW{1'b0}}, lit};
  assign a_op    = (ra_idx == ZERO_REG) ? '0 : ra_val;
  assign rb_z    = (rb_idx == ZERO_REG) ? '0 : rb_val;
  assign b_op    = use_lit ? lit_ext : rb_z;

endmodule

// File: rtl/iexe_alu.sv
module iexe_alu
  import iexe_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int LW   = 32
) (
  input  alu_op_e         op,
  input  logic            is_long,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] res,
  output logic            ovf
);

  localparam int HIW = XLEN - LW;

  logic            sub;
  logic [XLEN-1:0] b_eff;
  logic [XLEN-1:0] sum;
  logic [XLEN-1:0] sum_long;
  logic            q_ovf;
  logic            l_ovf;

  assign sub   = (op == ALU_SUB);
  assign b_eff = sub ? ~b : b;
  assign sum   = a + b_eff + {{(XLEN-1){1'b0}}, sub};

  assign q_ovf = (a[XLEN-1] == b_eff[XLEN-1]) && (sum[XLEN-1] != a[XLEN-1]);
  assign l_ovf = (a[LW-1] == b_eff[LW-1]) && (sum[LW-1] != a[LW-1]);

  generate
    if (HIW > 0) begin : g_sext
      assign sum_long = {{HIW{sum[LW-1]}}, sum[LW-1:0]};
    end else begin : g_full
      assign sum_long = sum;
    end
  endgenerate

  always_comb begin
    ovf = 1'b0;
    unique case (op)
      ALU_ADD, ALU_SUB: begin
        res = is_long ? sum_long : sum;
        ovf = is_long ? l_ovf : q_ovf;
      end
      ALU_AND:  res = a & b;
      ALU_OR:   res = a | b;
      ALU_XOR:  res = a ^ b;
      ALU_CEQ:  res = {{(XLEN-1){1'b0}}, (a == b)};
      ALU_CLT:  res = {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
      ALU_CULT: res = {{(XLEN-1){1'b0}}, (a < b)};
      default:  res = '0;
    endcase
  end

endmodule

// File: rtl/iexe_agu.sv
module iexe_agu
  import iexe_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0]  base,
  input  logic [DISPW-1:0] disp,
  output logic [XLEN-1:0]  ea
);

  localparam int PADW = XLEN - DISPW;

  logic [XLEN-1:0] disp_ext;

  assign disp_ext = {{PADW{disp[DISPW-1]}}, disp};
  assign ea       = base + disp_ext;

endmodule

// File: rtl/iexe_unit.sv
module iexe_unit
  import iexe_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int LW   = 32,
  parameter int IW   = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [IW-1:0]   instr,
  input  logic [XLEN-1:0] ra_val,
  input  logic [XLEN-1:0] rb_val,
  output logic            out_valid,
  output logic            wr_en,
  output logic [IDXW-1:0] wr_idx,
  output logic [XLEN-1:0] wr_data,
  output logic            addr_valid,
  output logic [XLEN-1:0] addr,
  output logic            ovf_trap,
  output logic            illegal
);

  dec_t             dec;
  logic [IDXW-1:0]  ra_idx, rb_idx, rc_idx;
  logic [LITW-1:0]  lit;
  logic [DISPW-1:0] disp;
  logic [XLEN-1:0]  a_op, b_op, rb_z;
  logic [XLEN-1:0]  alu_res, ea;
  logic             alu_ovf;
  logic             int_ok, trap_n, wen_n, mem_n, bad_n;

  iexe_decode #(.IW(IW)) u_dec (
    .instr  (instr),
    .dec    (dec),
    .ra_idx (ra_idx),
    .rb_idx (rb_idx),
    .rc_idx (rc_idx),
    .lit    (lit),
    .disp   (disp)
  );

  iexe_opsel #(.XLEN(XLEN)) u_opsel (
    .ra_idx  (ra_idx),
    .rb_idx  (rb_idx),
    .ra_val  (ra_val),
    .rb_val  (rb_val),
    .lit     (lit),
    .use_lit (dec.use_lit),
    .a_op    (a_op),
    .rb_z    (rb_z),
    .b_op    (b_op)
  );

  iexe_alu #(.XLEN(XLEN), .LW(LW)) u_alu (
    .op      (dec.op),
    .is_long (dec.is_long),
    .a       (a_op),
    .b       (b_op),
    .res     (alu_res),
    .ovf     (alu_ovf)
  );

  iexe_agu #(.XLEN(XLEN)) u_agu (
    .base (rb_z),
    .disp (disp),
    .ea   (ea)
  );

  assign int_ok = in_valid && dec.is_int && !dec.bad;
  assign trap_n = int_ok && dec.ovf_en && alu_ovf;
  assign wen_n  = int_ok && !trap_n && (rc_idx != ZERO_REG);
  assign mem_n  = in_valid && dec.is_mem;
  assign bad_n  = in_valid && dec.bad;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      wr_en      <= 1'b0;
      wr_idx     <= '0;
      wr_data    <= '0;
      addr_valid <= 1'b0;
      addr       <= '0;
      ovf_trap   <= 1'b0;
      illegal    <= 1'b0;
    end else begin
      out_valid  <= in_valid;
      wr_en      <= wen_n;
      wr_idx     <= rc_idx;
      wr_data    <= alu_res;
      addr_valid <= mem_n;
      addr       <= ea;
      ovf_trap   <= trap_n;
      illegal    <= bad_n;
    end
  end

endmodule

// File: rtl/iexe_unit_chk.sv
module iexe_unit_chk
  import iexe_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int LW   = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic [OPW-1:0]  op_i,
  input logic [FNW-1:0]  fn_i,
  input logic            out_valid,
  input logic            wr_en,
  input logic [IDXW-1:0] wr_idx,
  input logic [XLEN-1:0] wr_data,
  input logic            addr_valid,
  input logic            ovf_trap,
  input logic            illegal
);

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (out_valid == $past(in_valid)));

  // R11
  rc_zero_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (out_valid && wr_idx != ZERO_REG));

  // R9
  trap_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_trap |-> !wr_en);

  // R10
  mem_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
    addr_valid |-> (!wr_en && !illegal && !ovf_trap));

  // R12
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    illegal |-> (!wr_en && !ovf_trap && !addr_valid));

  // R6
  long_sext_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && $past(op_i) == OPC_INT &&
     ($past(fn_i[5:0]) == FN_ADDL || $past(fn_i[5:0]) == FN_SUBL))
    |-> (wr_data[XLEN-1:LW] == {(XLEN-LW){wr_data[LW-1]}}));

  // R8
  cmp_bool_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && $past(op_i) == OPC_INT &&
     ($past(fn_i[5:0]) == FN_CEQ || $past(fn_i[5:0]) == FN_CLT ||
      $past(fn_i[5:0]) == FN_CULT))
    |-> (wr_data[XLEN-1:1] == '0));

endmodule

bind iexe_unit iexe_unit_chk #(.XLEN(XLEN), .LW(LW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .op_i       (instr[IW-1:IW-OPW]),
  .fn_i       (instr[IDXW +: FNW]),
  .out_valid  (out_valid),
  .wr_en      (wr_en),
  .wr_idx     (wr_idx),
  .wr_data    (wr_data),
  .addr_valid (addr_valid),
  .ovf_trap   (ovf_trap),
  .illegal    (illegal)
);

// File: tb/iexe_unit_tb.sv
module iexe_unit_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 31;

  typedef struct packed {
    logic [3:0]  req;
    logic [31:0] ins;
    logic [63:0] a;
    logic [63:0] b;
    logic        wen;
    logic [63:0] data;
    logic        trap;
    logic        ill;
    logic        av;
    logic [63:0] ea;
  } vec_t;

  function automatic logic [31:0] f_op(logic [6:0] fn, logic [4:0] ra, logic [4:0] rb, logic [4:0] rc);
    return {6'h12, ra, rb, 3'b000, 1'b0, fn, rc};
  endfunction

  function automatic logic [31:0] f_lit(logic [6:0] fn, logic [4:0] ra, logic [7:0] l, logic [4:0] rc);
    return {6'h12, ra, l, 1'b1, fn, rc};
  endfunction

  function automatic logic [31:0] f_mem(logic [5:0] op, logic [4:0] ra, logic [4:0] rb, logic [15:0] d);
    return {op, ra, rb, d};
  endfunction

  function automatic vec_t mkv(logic [3:0] r, logic [31:0] i, logic [63:0] a, logic [63:0] b,
                               logic w, logic [63:0] d, logic t, logic il, logic av, logic [63:0] ea);
    return '{req: r, ins: i, a: a, b: b, wen: w, data: d, trap: t, ill: il, av: av, ea: ea};
  endfunction

  localparam vec_t VT [NV] = '{
    // R5 quadword add and subtract
    mkv(5, f_op(7'h01, 1, 2, 3), 64'd5, 64'd7, 1, 64'd12, 0, 0, 0, 0),
    mkv(5, f_op(7'h02, 1, 2, 3), 64'd5, 64'd7, 1, 64'hFFFF_FFFF_FFFF_FFFE, 0, 0, 0, 0),
    // R6 longword wrap into sign
    mkv(6, f_op(7'h03, 1, 2, 3), 64'h7FFF_FFFF, 64'd1, 1, 64'hFFFF_FFFF_8000_0000, 0, 0, 0, 0),
    // R9 longword qualifier traps, quadword qualifier does not on same values
    mkv(9, f_op(7'h43, 1, 2, 3), 64'h7FFF_FFFF, 64'd1, 0, 64'd0, 1, 0, 0, 0),
    mkv(9, f_op(7'h41, 1, 2, 3), 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 0, 64'd0, 1, 0, 0, 0),
    mkv(9, f_op(7'h41, 1, 2, 3), 64'h7FFF_FFFF, 64'd1, 1, 64'h8000_0000, 0, 0, 0, 0),
    mkv(9, f_op(7'h44, 1, 2, 3), 64'h8000_0000, 64'd1, 0, 64'd0, 1, 0, 0, 0),
    // R6 upper input bits ignored, carry out dropped
    mkv(6, f_op(7'h04, 1, 2, 3), 64'h1_0000_0005, 64'd3, 1, 64'd2, 0, 0, 0, 0),
    mkv(6, f_op(7'h03, 1, 2, 3), 64'hFFFF_FFFF, 64'd1, 1, 64'd0, 0, 0, 0, 0),
    // R7 logic
    mkv(7, f_op(7'h10, 1, 2, 3), 64'hF0F0, 64'hFF00, 1, 64'hF000, 0, 0, 0, 0),
    mkv(7, f_op(7'h11, 1, 2, 3), 64'hF0F0, 64'hFF00, 1, 64'hFFF0, 0, 0, 0, 0),
    mkv(7, f_op(7'h12, 1, 2, 3), 64'hF0F0, 64'hFF00, 1, 64'h0FF0, 0, 0, 0, 0),
    // R8 compares
    mkv(8, f_op(7'h21, 1, 2, 3), '1, 64'd1, 1, 64'd1, 0, 0, 0, 0),
    mkv(8, f_op(7'h22, 1, 2, 3), '1, 64'd1, 1, 64'd0, 0, 0, 0, 0),
    mkv(8, f_op(7'h20, 1, 2, 3), 64'd5, 64'd5, 1, 64'd1, 0, 0, 0, 0),
    mkv(8, f_op(7'h20, 1, 2, 3), 64'd5, 64'd6, 1, 64'd0, 0, 0, 0, 0),
    mkv(8, f_op(7'h22, 1, 2, 3), 64'd1, '1, 1, 64'd1, 0, 0, 0, 0),
    // R3 literal operand, field looks like index 31, bit 7 set
    mkv(3, f_lit(7'h01, 1, 8'hFF, 3), 64'd1, 64'hDEAD, 1, 64'h100, 0, 0, 0, 0),
    mkv(3, f_lit(7'h12, 1, 8'h80, 3), '1, 64'hDEAD, 1, 64'hFFFF_FFFF_FFFF_FF7F, 0, 0, 0, 0),
    // R4 zero register sources
    mkv(4, f_op(7'h01, 31, 2, 3), 64'h1234, 64'd5, 1, 64'd5, 0, 0, 0, 0),
    mkv(4, f_op(7'h02, 1, 31, 3), 64'd9, 64'h55, 1, 64'd9, 0, 0, 0, 0),
    // R11 result to index 31 dropped
    mkv(11, f_op(7'h01, 1, 2, 31), 64'd5, 64'd7, 0, 64'd0, 0, 0, 0, 0),
    // R12 illegal function, qualifier on logic, illegal opcode
    mkv(12, f_op(7'h7F, 1, 2, 3), 64'd5, 64'd7, 0, 64'd0, 0, 1, 0, 0),
    mkv(12, f_op(7'h50, 1, 2, 3), 64'd5, 64'd7, 0, 64'd0, 0, 1, 0, 0),
    mkv(12, 32'h0000_0000, 64'd5, 64'd7, 0, 64'd0, 0, 1, 0, 0),
    // R10 effective address
    mkv(10, f_mem(6'h28, 1, 2, 16'hFFF0), 64'd0, 64'h1000, 0, 64'd0, 0, 0, 1, 64'h0FF0),
    mkv(10, f_mem(6'h2F, 1, 2, 16'h7FFF), 64'd0, 64'd0, 0, 64'd0, 0, 0, 1, 64'h7FFF),
    mkv(10, f_mem(6'h2C, 1, 31, 16'h0010), 64'd0, 64'h999, 0, 64'd0, 0, 0, 1, 64'h10),
    mkv(10, f_mem(6'h29, 1, 2, 16'h8000), 64'd0, 64'd0, 0, 64'd0, 0, 0, 1, 64'hFFFF_FFFF_FFFF_8000),
    // R9 quadword subtract overflow with and without qualifier
    mkv(9, f_op(7'h42, 1, 2, 3), 64'h8000_0000_0000_0000, 64'd1, 0, 64'd0, 1, 0, 0, 0),
    mkv(9, f_op(7'h02, 1, 2, 3), 64'h8000_0000_0000_0000, 64'd1, 1, 64'h7FFF_FFFF_FFFF_FFFF, 0, 0, 0, 0)
  };

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [31:0] instr;
  logic [63:0] ra_val, rb_val;
  logic        out_valid, wr_en, addr_valid, ovf_trap, illegal;
  logic [4:0]  wr_idx;
  logic [63:0] wr_data, addr;

  int  n_run  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  iexe_unit u_dut (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .instr      (instr),
    .ra_val     (ra_val),
    .rb_val     (rb_val),
    .out_valid  (out_valid),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .wr_data    (wr_data),
    .addr_valid (addr_valid),
    .addr       (addr),
    .ovf_trap   (ovf_trap),
    .illegal    (illegal)
  );

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic all_clear(string req);
    chk(req, "out_valid", {63'd0, out_valid}, 64'd0);
    chk(req, "wr_en", {63'd0, wr_en}, 64'd0);
    chk(req, "wr_data", wr_data, 64'd0);
    chk(req, "addr_valid", {63'd0, addr_valid}, 64'd0);
    chk(req, "addr", addr, 64'd0);
    chk(req, "ovf_trap", {63'd0, ovf_trap}, 64'd0);
    chk(req, "illegal", {63'd0, illegal}, 64'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R2 watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; instr = '0; ra_val = '0; rb_val = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    all_clear("R1");
    rst = 1'b0;

    // table walk: R2 through R12
    for (int i = 0; i < NV; i++) begin
      string r;
      r = $sformatf("R%0d", VT[i].req);
      @(negedge clk);
      in_valid = 1'b1; instr = VT[i].ins; ra_val = VT[i].a; rb_val = VT[i].b;
      @(negedge clk);
      in_valid = 1'b0;
      chk("R2", $sformatf("out_valid v%0d", i), {63'd0, out_valid}, 64'd1);
      chk(r, $sformatf("wr_en v%0d", i), {63'd0, wr_en}, {63'd0, VT[i].wen});
      if (VT[i].wen) begin
        chk(r, $sformatf("wr_data v%0d", i), wr_data, VT[i].data);
        chk("R2", $sformatf("wr_idx v%0d", i), {59'd0, wr_idx}, {59'd0, VT[i].ins[4:0]});
      end
      chk(r, $sformatf("ovf_trap v%0d", i), {63'd0, ovf_trap}, {63'd0, VT[i].trap});
      chk(r, $sformatf("illegal v%0d", i), {63'd0, illegal}, {63'd0, VT[i].ill});
      chk(r, $sformatf("addr_valid v%0d", i), {63'd0, addr_valid}, {63'd0, VT[i].av});
      if (VT[i].av) chk(r, $sformatf("addr v%0d", i), addr, VT[i].ea);
    end

    // R2 idle cycle: no valid in, nothing out
    @(negedge clk);
    chk("R2", "idle out_valid", {63'd0, out_valid}, 64'd0);
    chk("R2", "idle wr_en", {63'd0, wr_en}, 64'd0);

    // R1 reset wins over a valid instruction
    in_valid = 1'b1; instr = f_op(7'h01, 1, 2, 3); ra_val = 64'd4; rb_val = 64'd4; rst = 1'b1;
    @(negedge clk);
    all_clear("R1");
    rst = 1'b0;

    // R5 back-to-back issue, each result one cycle after its input
    @(negedge clk);
    chk("R5", "b2b first", wr_data, 64'd8);
    instr = f_op(7'h02, 1, 2, 3); ra_val = 64'd10; rb_val = 64'd3;
    @(negedge clk);
    chk("R5", "b2b second", wr_data, 64'd7);
    in_valid = 1'b0;

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule